// File: doc/BRIEF.md
# Aging-Adaptive Hold Controller

This block sits beside a bypassing array multiplier and decides, one operand pair at a time, whether the product can settle within one clock or needs two. It counts the zero bits of the operand that steers the array's bypass muxes. In column mode that operand is the multiplicand, and in row mode it is the multiplier. The zero count is compared against a loose threshold or a strict threshold. The decision is registered and drives `one_cycle`. A low value holds the enable of the result register for one extra cycle.

A timing-error flag comes back from the error-detecting result register. When that flag rises on an operation that was let through in one cycle, the controller forces a hold cycle so that the operation is repeated, and it counts the event. Errors are tallied over a fixed window of operations, and the tally is cleared at the end of each window. If a window collects more errors than a set limit, the block decides that the circuit has slowed down. It raises `aged` and keeps it high until reset. From then on it uses the strict threshold, so fewer patterns qualify for one cycle.

Top module: `aging_hold_ctrl`

## Requirements
- R1: After reset, `one_cycle` is 1 and `aged` is 0.
- R2: While `aged` is 0, an accepted operand (`in_valid`=1, no repeat pending) sets `one_cycle` one clock later to 1 exactly when the operand has more than N zero bits, and to 0 otherwise.
- R3: While `aged` is 1, the same decision uses the limit N+1: `one_cycle` becomes 1 only when the operand has more than N+1 zero bits.
- R4: A `razor_error` seen while `one_cycle` is 1 drives `one_cycle` to 0 on the next clock and counts as one error. This takes priority over an operand presented in the same cycle.
- R5: A `razor_error` seen while `one_cycle` is 0 is ignored. It causes no hold and adds nothing to the error tally.
- R6: A cycle with no accepted operand and no repeat drives `one_cycle` to 1 on the next clock.
- R7: Every WINDOW accepted operands, the error tally is cleared. Errors from earlier windows never add to a later window's tally.
- R8: `aged` goes to 1 on the clock at which the error tally of the current window reaches ERR_THRESH+1.
- R9: Once `aged` is 1 it stays 1 until `rst_n` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op | input | M | Bypass-controlling operand (multiplicand or multiplier) |
| in_valid | input | 1 | A new operand pair is presented this cycle |
| razor_error | input | 1 | Timing-error flag from the result register |
| one_cycle | output | 1 | 1: result may be taken next cycle; 0: hold one cycle |
| aged | output | 1 | Sticky flag, strict threshold in use |

## Verification
The hardest situation to reach from the ports is the window boundary. The error tally has to sit exactly at the limit when an old window closes, so that only the clearing keeps `aged` low. The bench starts from a fresh reset so it knows the window phase. It lands ERR_THRESH counted errors in the first window, fills the rest of that window with clean operands, and then lands ERR_THRESH more. At that point a flag that had been ignored and one more real error separate R5, R7 and R8.

// File: rtl/aging_hold_pkg.sv
package aging_hold_pkg;

    // Decision encoding carried on one_cycle.
    typedef enum logic {
        LAT_TWO = 1'b0,
        LAT_ONE = 1'b1
    } latency_e;

endpackage

// File: rtl/ahl_zero_count.sv
module ahl_zero_count #(
    parameter int M  = 16,
    parameter int ZW = $clog2(M + 1)
) (
    input  logic [M-1:0]  op,
    output logic [ZW-1:0] zeros
);

    logic [M-1:0] is_zero;

    for (genvar b = 0; b < M; b++) begin : g_bit
        assign is_zero[b] = ~op[b];
    end

    always_comb begin
        zeros = '0;
        for (int i = 0; i < M; i++) begin
            zeros = zeros + ZW'(is_zero[i]);
        end
    end

endmodule

// File: rtl/ahl_judge.sv
module ahl_judge #(
    parameter int M  = 16,
    parameter int N  = 8,
    parameter int ZW = $clog2(M + 1)
) (
    input  logic [ZW-1:0] zeros,
    input  logic          strict,
    output logic          pass
);

    logic [1:0] pass_vec;

    // Block 0 uses limit N, block 1 uses limit N+1.
    for (genvar g = 0; g < 2; g++) begin : g_block
        assign pass_vec[g] = int'(zeros) > (N + g);
    end

    assign pass = strict ? pass_vec[1] : pass_vec[0];

endmodule

// File: rtl/ahl_aging_monitor.sv
module ahl_aging_monitor #(
    parameter int WINDOW     = 256,
    parameter int ERR_THRESH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic op_done,
    input  logic err_hit,
    output logic aged
);

    localparam int OW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam int EW = $clog2(ERR_THRESH + 2);
    localparam logic [OW-1:0] WLAST = OW'(WINDOW - 1);
    localparam logic [EW-1:0] ELIM  = EW'(ERR_THRESH + 1);

    typedef struct packed {
        logic [OW-1:0] op_cnt;
        logic [EW-1:0] err_cnt;
        logic          aged;
    } mon_t;

    mon_t st_d, st_q;
    logic          wrap;
    logic [EW-1:0] err_sum;

    always_comb begin
        st_d    = st_q;
        wrap    = op_done && (st_q.op_cnt == WLAST);
        err_sum = st_q.err_cnt;
        if (err_hit && (st_q.err_cnt != ELIM)) begin
            err_sum = st_q.err_cnt + EW'(1);
        end
        if (int'(err_sum) > ERR_THRESH) begin
            st_d.aged = 1'b1;
        end
        if (op_done) begin
            st_d.op_cnt = wrap ? '0 : st_q.op_cnt + OW'(1);
        end
        st_d.err_cnt = wrap ? '0 : err_sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign aged = st_q.aged;

    AST_WINDOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && st_q.op_cnt == WLAST) |=> (st_q.op_cnt == '0 && st_q.err_cnt == '0)) // R7
        else $error("window did not clear");

    AST_AGED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.aged) |-> $past(err_hit)) // R8
        else $error("aged rose without an error");

endmodule

// File: rtl/aging_hold_ctrl.sv
module aging_hold_ctrl
    import aging_hold_pkg::*;
#(
    parameter int M          = 16,
    parameter int N          = 8,
    parameter int WINDOW     = 256,
    parameter int ERR_THRESH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [M-1:0] op,
    input  logic         in_valid,
    input  logic         razor_error,
    output logic         one_cycle,
    output logic         aged
);

    localparam int ZW = $clog2(M + 1);

    typedef struct packed {
        latency_e lat;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [ZW-1:0] zeros;
    logic          pass;
    logic          replay;

    ahl_zero_count #(.M(M), .ZW(ZW)) u_zeros (
        .op    (op),
        .zeros (zeros)
    );

    ahl_judge #(.M(M), .N(N), .ZW(ZW)) u_judge (
        .zeros  (zeros),
        .strict (aged),
        .pass   (pass)
    );

    assign replay = razor_error && (ctl_q.lat == LAT_ONE);

    ahl_aging_monitor #(.WINDOW(WINDOW), .ERR_THRESH(ERR_THRESH)) u_monitor (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_done (in_valid),
        .err_hit (replay),
        .aged    (aged)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (replay) begin
            ctl_d.lat = LAT_TWO;
        end else if (in_valid) begin
            ctl_d.lat = pass ? LAT_ONE : LAT_TWO;
        end else begin
            ctl_d.lat = LAT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.lat <= LAT_ONE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign one_cycle = (ctl_q.lat == LAT_ONE);

    AST_REPLAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (razor_error && one_cycle) |=> !one_cycle) // R4
        else $error("no hold after error");

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !(razor_error && one_cycle)) |=> one_cycle) // R6
        else $error("idle cycle left hold asserted");

    AST_AGED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        aged |=> aged) // R9
        else $error("aged dropped");

endmodule

// File: tb/aging_hold_ctrl_bench.sv
`timescale 1ns/1ps
module aging_hold_ctrl_bench;

    localparam int M  = 8;
    localparam int N  = 4;
    localparam int WIN = 16;
    localparam int ETH = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [M-1:0] op = '0;
    logic         in_valid = 1'b0;
    logic         razor_error = 1'b0;
    logic         one_cycle;
    logic         aged;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    aging_hold_ctrl #(.M(M), .N(N), .WINDOW(WIN), .ERR_THRESH(ETH)) u_aging_hold_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .in_valid    (in_valid),
        .razor_error (razor_error),
        .one_cycle   (one_cycle),
        .aged        (aged)
    );

    function automatic int zcount(input logic [M-1:0] v);
        int z = 0;
        for (int i = 0; i < M; i++) if (!v[i]) z++;
        return z;
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    // Drive at negedge, clock once, return at the next negedge.
    task automatic step(input logic v, input logic [M-1:0] o, input logic e);
        in_valid = v; op = o; razor_error = e;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; razor_error = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One counted error: a pass pattern, then an error on it.
    task automatic counted_error();
        step(1'b1, '0, 1'b0);
        step(1'b0, '0, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog got hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 one_cycle", one_cycle, 1'b1);
        chk("R1 aged", aged, 1'b0);

        // R2: full sweep, fresh threshold.
        for (int v = 0; v < (1 << M); v++) begin
            step(1'b1, M'(v), 1'b0);
            chk("R2 fresh judge", one_cycle, zcount(M'(v)) > N);
        end

        // R4: error on one-cycle op, with a passing op presented.
        step(1'b1, '0, 1'b0);
        chk("R2 pass", one_cycle, 1'b1);
        step(1'b1, '0, 1'b1);
        chk("R4 replay beats new op", one_cycle, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R6 idle release", one_cycle, 1'b1);

        // Window tests from known phase.
        do_reset();
        for (int k = 0; k < ETH; k++) counted_error();
        chk("R8 at limit not aged", aged, 1'b0);
        for (int k = 0; k < WIN - ETH; k++) step(1'b1, '1, 1'b0);
        for (int k = 0; k < ETH; k++) counted_error();
        chk("R7 old errors cleared", aged, 1'b0);

        // R5: error while holding is ignored.
        step(1'b1, '1, 1'b0);
        chk("R2 two-cycle op", one_cycle, 1'b0);
        step(1'b0, '0, 1'b1);
        chk("R5 no hold from ignored error", one_cycle, 1'b1);
        chk("R5 ignored error not counted", aged, 1'b0);

        counted_error();
        chk("R8 aged after limit+1", aged, 1'b1);
        chk("R4 hold on counted error", one_cycle, 1'b0);

        for (int k = 0; k < 3 * WIN; k++) step(1'b1, '1, 1'b0);
        chk("R9 aged sticky", aged, 1'b1);

        // R3: full sweep, strict threshold.
        for (int v = 0; v < (1 << M); v++) begin
            step(1'b1, M'(v), 1'b0);
            chk("R3 strict judge", one_cycle, zcount(M'(v)) > N + 1);
        end

        do_reset();
        chk("R1 aged cleared by reset", aged, 1'b0);
        chk("R1 one_cycle after reset", one_cycle, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule